// File: doc/BRIEF.md
# Backplane Slot-Select Frame Generator

This block is the host-side master that opens a conversation with one module on a backplane serial bus. A request carries a 5-bit chassis address and a 4-bit slot number. The generator pulls an active-low select strobe down and shifts the nine address bits out on a serial data line under its own serial clock. It then releases the strobe and reports completion only once the addressed module has had time to enable its select.

Every bus interval is derived from a nanosecond figure and the system-clock period, both given as parameters, and rounded up to whole system clocks. This way each minimum spacing holds at the configured clock frequency. The high and low phases of the serial clock are set directly in system clocks. While a frame is in flight the request port refuses new work, so no other traffic can reach the bus while the previously selected module is still dropping its select.

Top module: `ssel_frame_gen`

## Requirements
- R1: Out of reset and between frames, the strobe is high (1), the serial clock is low (0), the serial data line is low, ready is high and done is low.
- R2: A request is taken on a rising clock edge where valid and ready are both high. The strobe falls on that same edge, and ready stays low from then until the cycle in which done is high.
- R3: Each strobe-low window has exactly 9 rising serial-clock edges. The bits sent are chassis bit 4 down to chassis bit 0, then slot bit 3 down to slot bit 0.
- R4: The first rising serial-clock edge comes ceil(LEAD_NS*1000/CLK_PS) system clocks after the strobe falls. This is 15 with the defaults.
- R5: The serial clock stays high for SCLK_HI system clocks, and consecutive rising edges are SCLK_HI+SCLK_LO system clocks apart (4 and 8 with the defaults).
- R6: Serial data changes only on the edge where the serial clock falls. It is stable on each rising edge and throughout each high phase.
- R7: The strobe rises max(ceil(TRAIL_NS*1000/CLK_PS), SCLK_HI+1) system clocks after the last rising serial-clock edge. This is 50 with the defaults.
- R8: Done is a one-cycle pulse that comes ceil(SETTLE_NS*1000/CLK_PS) system clocks after the strobe rises (70 with the defaults). Ready returns high in that same cycle.
- R9: A request presented while ready is low is ignored. It does not change the frame in flight, and it does not start a new frame unless it is still presented once ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Generator idle and able to take a request |
| req_chassis_i | input | CHASSIS_W | Chassis address to send first |
| req_slot_i | input | SLOT_W | Slot number to send second |
| done_o | output | 1 | One-cycle pulse once the select-enable delay has elapsed |
| strobe_no | output | 1 | Active-low select strobe |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |

## Verification
The bench sends the select frame for chassis 9, slot 11. It also sends all-zero and all-one address pairs, which show whether clock pulses and strobe framing are right even when the data line carries no edges, and two complementary alternating patterns, which catch reversed bit order or swapped fields. One frame has a conflicting request held through its whole active window, which separates a generator that refuses work while busy from one that latches it. Frames are also issued back to back, so that the return of ready together with done is exercised.

// File: rtl/ssel_pkg.sv
`timescale 1ns/1ps
package ssel_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LEAD,
      S_HI,
      S_LO,
      S_TRAIL,
      S_SETTLE
   } ssel_state_e;

   // Interval in ns converted to whole system clocks, rounded up, never zero.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
      int unsigned c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ssel_timer.sv
`timescale 1ns/1ps
// Down-counter: after a load of N, expired_o is high in the Nth following cycle.
module ssel_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ssel_shifter.sv
`timescale 1ns/1ps
// MSB-first serializer with a remaining-bit count.
module ssel_shifter #(
   parameter int FRAME_W = 9
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               shift_i,
   output logic               bit_o,
   output logic               last_o
);

   localparam int RW = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sh_q;
   logic [RW-1:0]      rem_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         rem_q <= '0;
      end else if (load_i) begin
         sh_q  <= frame_i;
         rem_q <= RW'(FRAME_W);
      end else if (shift_i) begin
         sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
         rem_q <= rem_q - RW'(1);
      end
   end

   assign bit_o  = sh_q[FRAME_W-1];
   assign last_o = (rem_q == RW'(1));

endmodule

// File: rtl/ssel_ctrl.sv
`timescale 1ns/1ps
// Sequencer: lead gap, clock phases, trailing gap, select-enable wait.
module ssel_ctrl
   import ssel_pkg::*;
#(
   parameter int          CNT_W      = 8,
   parameter int unsigned LEAD_CYC   = 15,
   parameter int unsigned HI_CYC     = 4,
   parameter int unsigned LO_CYC     = 4,
   parameter int unsigned TRAIL_REM  = 46,
   parameter int unsigned SETTLE_CYC = 70
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_valid_i,
   input  logic             tmr_expired_i,
   input  logic             last_bit_i,
   output logic             req_ready_o,
   output logic             tmr_load_o,
   output logic [CNT_W-1:0] tmr_val_o,
   output logic             frame_load_o,
   output logic             frame_shift_o,
   output logic             strobe_no,
   output logic             sclk_o,
   output logic             data_en_o,
   output logic             done_o
);

   ssel_state_e st_q, st_d;
   logic        accept;

   assign req_ready_o  = (st_q == S_IDLE);
   assign accept       = req_ready_o && req_valid_i;
   assign frame_load_o = accept;

   always_comb begin
      st_d          = st_q;
      tmr_load_o    = 1'b0;
      tmr_val_o     = '0;
      frame_shift_o = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (accept) begin
               st_d       = S_LEAD;
               tmr_load_o = 1'b1;
               tmr_val_o  = CNT_W'(LEAD_CYC);
            end
         end
         S_LEAD, S_LO: begin
            if (tmr_expired_i) begin
               st_d       = S_HI;
               tmr_load_o = 1'b1;
               tmr_val_o  = CNT_W'(HI_CYC);
            end
         end
         S_HI: begin
            if (tmr_expired_i) begin
               tmr_load_o = 1'b1;
               if (last_bit_i) begin
                  st_d      = S_TRAIL;
                  tmr_val_o = CNT_W'(TRAIL_REM);
               end else begin
                  st_d          = S_LO;
                  tmr_val_o     = CNT_W'(LO_CYC);
                  frame_shift_o = 1'b1;
               end
            end
         end
         S_TRAIL: begin
            if (tmr_expired_i) begin
               st_d       = S_SETTLE;
               tmr_load_o = 1'b1;
               tmr_val_o  = CNT_W'(SETTLE_CYC);
            end
         end
         S_SETTLE: begin
            if (tmr_expired_i) st_d = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= S_IDLE;
         strobe_no <= 1'b1;
         sclk_o    <= 1'b0;
         data_en_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         st_q      <= st_d;
         strobe_no <= !(st_d inside {S_LEAD, S_HI, S_LO, S_TRAIL});
         data_en_o <=  (st_d inside {S_LEAD, S_HI, S_LO, S_TRAIL});
         sclk_o    <= (st_d == S_HI);
         done_o    <= (st_q == S_SETTLE) && (st_d == S_IDLE);
      end
   end

endmodule

// File: rtl/ssel_frame_gen.sv
`timescale 1ns/1ps
module ssel_frame_gen
   import ssel_pkg::*;
#(
   parameter int          CHASSIS_W = 5,
   parameter int          SLOT_W    = 4,
   parameter int unsigned CLK_PS    = 5000,
   parameter int unsigned LEAD_NS   = 75,
   parameter int unsigned TRAIL_NS  = 250,
   parameter int unsigned SETTLE_NS = 350,
   parameter int unsigned SCLK_HI   = 4,
   parameter int unsigned SCLK_LO   = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 req_valid_i,
   output logic                 req_ready_o,
   input  logic [CHASSIS_W-1:0] req_chassis_i,
   input  logic [SLOT_W-1:0]    req_slot_i,
   output logic                 done_o,
   output logic                 strobe_no,
   output logic                 sclk_o,
   output logic                 sdata_o
);

   localparam int          FRAME_W    = CHASSIS_W + SLOT_W;
   localparam int unsigned LEAD_CYC   = ns_to_cyc(LEAD_NS, CLK_PS);
   localparam int unsigned TRAIL_CYC  = ns_to_cyc(TRAIL_NS, CLK_PS);
   localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PS);
   // The last high phase counts toward the trailing gap.
   localparam int unsigned TRAIL_REM  = (TRAIL_CYC > SCLK_HI) ? TRAIL_CYC - SCLK_HI : 1;
   localparam int unsigned MAX_CYC    = max_u(max_u(LEAD_CYC, TRAIL_REM),
                                              max_u(SETTLE_CYC, max_u(SCLK_HI, SCLK_LO)));
   localparam int          CNT_W      = $clog2(MAX_CYC + 1);

   generate
      if (CHASSIS_W < 1 || SLOT_W < 1) begin : g_bad_fields
         $error("ssel_frame_gen: address fields must be at least one bit wide");
      end
      if (FRAME_W < 2) begin : g_bad_frame
         $error("ssel_frame_gen: frame must hold at least two bits");
      end
      if (SCLK_HI < 1 || SCLK_LO < 1) begin : g_bad_phase
         $error("ssel_frame_gen: serial clock phases must be at least one cycle");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("ssel_frame_gen: clock period must be positive");
      end
   endgenerate

   logic               tmr_load, tmr_expired;
   logic [CNT_W-1:0]   tmr_val;
   logic               frame_load, frame_shift, frame_bit, last_bit, data_en;
   logic [FRAME_W-1:0] frame;

   assign frame = {req_chassis_i, req_slot_i};

   ssel_ctrl #(
      .CNT_W     (CNT_W),
      .LEAD_CYC  (LEAD_CYC),
      .HI_CYC    (SCLK_HI),
      .LO_CYC    (SCLK_LO),
      .TRAIL_REM (TRAIL_REM),
      .SETTLE_CYC(SETTLE_CYC)
   ) u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i),
      .tmr_expired_i(tmr_expired),
      .last_bit_i   (last_bit),
      .req_ready_o  (req_ready_o),
      .tmr_load_o   (tmr_load),
      .tmr_val_o    (tmr_val),
      .frame_load_o (frame_load),
      .frame_shift_o(frame_shift),
      .strobe_no    (strobe_no),
      .sclk_o       (sclk_o),
      .data_en_o    (data_en),
      .done_o       (done_o)
   );

   ssel_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (tmr_load),
      .load_val_i(tmr_val),
      .expired_o (tmr_expired)
   );

   ssel_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (frame_load),
      .frame_i(frame),
      .shift_i(frame_shift),
      .bit_o  (frame_bit),
      .last_o (last_bit)
   );

   assign sdata_o = data_en & frame_bit;

endmodule

// File: rtl/ssel_frame_chk.sv
`timescale 1ns/1ps
module ssel_frame_chk
   import ssel_pkg::*;
#(
   parameter int          FRAME_W   = 9,
   parameter int unsigned CLK_PS    = 5000,
   parameter int unsigned LEAD_NS   = 75,
   parameter int unsigned TRAIL_NS  = 250,
   parameter int unsigned SETTLE_NS = 350
) (
   input logic clk_i,
   input logic rst_ni,
   input logic req_valid_i,
   input logic req_ready_o,
   input logic done_o,
   input logic strobe_no,
   input logic sclk_o,
   input logic sdata_o
);

   localparam int unsigned LEAD_CYC   = ns_to_cyc(LEAD_NS, CLK_PS);
   localparam int unsigned TRAIL_CYC  = ns_to_cyc(TRAIL_NS, CLK_PS);
   localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PS);

   logic [31:0] low_cnt, high_cnt, since_rise, rise_cnt;
   logic        sclk_prev;
   logic        rise_now;

   assign rise_now = sclk_o && !sclk_prev;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         low_cnt    <= '0;
         high_cnt   <= '0;
         since_rise <= '0;
         rise_cnt   <= '0;
         sclk_prev  <= 1'b0;
      end else begin
         sclk_prev  <= sclk_o;
         low_cnt    <= strobe_no ? '0 : ((low_cnt == '1) ? low_cnt : low_cnt + 1);
         high_cnt   <= !strobe_no ? '0 : ((high_cnt == '1) ? high_cnt : high_cnt + 1);
         since_rise <= rise_now ? 32'd1 : ((since_rise == '1) ? since_rise : since_rise + 1);
         rise_cnt   <= strobe_no ? '0 : (rise_now ? rise_cnt + 1 : rise_cnt);
      end
   end

   p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o |-> (strobe_no && !sclk_o && !sdata_o));

   p_fall_on_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(strobe_no) |-> $past(req_valid_i && req_ready_o));

   p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o) |=> !req_ready_o);

   p_sclk_framed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_o |-> !strobe_no);

   p_pulse_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(strobe_no) |-> (rise_cnt == 32'(FRAME_W)));

   p_lead_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_now |-> (low_cnt >= 32'(LEAD_CYC)));

   p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_o |-> $stable(sdata_o));

   p_trail_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(strobe_no) |-> (since_rise >= 32'(TRAIL_CYC)));

   p_settle_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (high_cnt >= 32'(SETTLE_CYC)));

   p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_done_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> req_ready_o);

   p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_no && !req_ready_o) |=> strobe_no);

endmodule

bind ssel_frame_gen ssel_frame_chk #(
   .FRAME_W  (CHASSIS_W + SLOT_W),
   .CLK_PS   (CLK_PS),
   .LEAD_NS  (LEAD_NS),
   .TRAIL_NS (TRAIL_NS),
   .SETTLE_NS(SETTLE_NS)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .req_valid_i(req_valid_i),
   .req_ready_o(req_ready_o),
   .done_o     (done_o),
   .strobe_no  (strobe_no),
   .sclk_o     (sclk_o),
   .sdata_o    (sdata_o)
);

// File: tb/ssel_frame_gen_tb.sv
`timescale 1ns/1ps
module ssel_frame_gen_tb_top;

   localparam int E_LEAD   = 15;  // ceil(75 ns / 5 ns)
   localparam int E_HI     = 4;
   localparam int E_PER    = 8;
   localparam int E_TRAIL  = 50;  // ceil(250 ns / 5 ns)
   localparam int E_SETTLE = 70;  // ceil(350 ns / 5 ns)
   localparam int E_BITS   = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [4:0] chassis = '0;
   logic [3:0] slot = '0;
   logic       req_ready, done, strobe_n, sclk, sdata;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int frames_done = 0;
   bit exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ssel_frame_gen dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid),
      .req_ready_o  (req_ready),
      .req_chassis_i(chassis),
      .req_slot_i   (slot),
      .done_o       (done),
      .strobe_no    (strobe_n),
      .sclk_o       (sclk),
      .sdata_o      (sdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Monitor: pops expected bits at each serial-clock rise, measures intervals.
   logic p_strobe = 1'b1, p_sclk = 1'b0, p_done = 1'b0, p_sdata = 1'b0;
   int   fall_c, rise_c, last_rise, lead, nrise;
   bit   phase_ok, hold_ok;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_strobe && !strobe_n) begin
            fall_c = cyc; nrise = 0; phase_ok = 1; hold_ok = 1;
         end
         if (!p_sclk && sclk) begin
            if (nrise == 0) lead = cyc - fall_c;
            else if (cyc - last_rise != E_PER) phase_ok = 0;
            last_rise = cyc;
            nrise++;
            if (exp_q.size() == 0) check(0, "R3", "unexpected serial bit", nrise, 0);
            else begin
               bit e;
               e = exp_q.pop_front();
               check(sdata == e, "R3", "serial bit value", int'(sdata), int'(e));
            end
         end
         if (sclk && p_sclk && sdata != p_sdata) hold_ok = 0;   // R6
         if (p_sclk && !sclk && (cyc - last_rise != E_HI)) phase_ok = 0;
         if (!p_strobe && strobe_n) begin
            rise_c = cyc;
            check(nrise == E_BITS, "R3", "rising edges per frame", nrise, E_BITS);
            check(lead == E_LEAD, "R4", "strobe fall to first rise", lead, E_LEAD);
            check(phase_ok, "R5", "clock phase widths", int'(phase_ok), 1);
            check(hold_ok, "R6", "data stable while clock high", int'(hold_ok), 1);
            check(cyc - last_rise == E_TRAIL, "R7", "last rise to strobe rise",
                  cyc - last_rise, E_TRAIL);
         end
         if (done) begin
            check(!p_done, "R8", "done width", 2, 1);
            check(cyc - rise_c == E_SETTLE, "R8", "strobe rise to done",
                  cyc - rise_c, E_SETTLE);
            check(req_ready, "R8", "ready with done", int'(req_ready), 1);
            frames_done++;
         end
      end
      p_strobe = strobe_n; p_sclk = sclk; p_done = done; p_sdata = sdata;
   end

   // Driver: queues the expected bits, then performs the handshake.
   task automatic send(input logic [4:0] c, input logic [3:0] s);
      for (int i = 4; i >= 0; i--) exp_q.push_back(c[i]);
      for (int i = 3; i >= 0; i--) exp_q.push_back(s[i]);
      @(negedge clk);
      chassis = c; slot = s; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready && !strobe_n, "R2", "busy and strobe low after accept",
            int'({req_ready, strobe_n}), 0);
   endtask

   task automatic wait_frames(input int n);
      while (frames_done < n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(strobe_n && !sclk && !sdata && req_ready && !done, "R1",
            "lines in reset", int'({strobe_n, sclk, sdata, req_ready, done}), 5'b10010);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(strobe_n && !sclk && !sdata && req_ready && !done, "R1",
            "idle lines after reset", int'({strobe_n, sclk, sdata, req_ready, done}), 5'b10010);

      send(5'd9, 4'd11);
      wait_frames(1);
      send(5'd0, 4'd0);
      wait_frames(2);
      send(5'h1f, 4'hf);
      wait_frames(3);
      send(5'h15, 4'ha);
      wait_frames(4);

      // R9: conflicting request held while the frame is active.
      send(5'h0a, 4'h5);
      repeat (20) @(negedge clk);
      chassis = 5'h1f; slot = 4'h0; req_valid = 1'b1;
      begin
         int ready_seen = 0;
         repeat (100) begin
            @(negedge clk);
            if (req_ready) ready_seen++;
         end
         check(ready_seen == 0, "R9", "ready while busy", ready_seen, 0);
      end
      req_valid = 1'b0;
      wait_frames(5);
      begin
         int falls = 0;
         repeat (20) begin
            @(negedge clk);
            if (!strobe_n) falls++;
         end
         check(falls == 0, "R9", "no frame from refused request", falls, 0);
      end
      check(strobe_n && !sclk && !sdata && req_ready, "R1", "idle lines between frames",
            int'({strobe_n, sclk, sdata, req_ready}), 4'b1001);

      // Back-to-back frames.
      send(5'd9, 4'd11);
      wait_frames(6);
      send(5'h03, 4'h6);
      wait_frames(7);

      check(exp_q.size() == 0, "R3", "bits left unsent", exp_q.size(), 0);
      check(frames_done == 7, "R8", "done pulses", frames_done, 7);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d frames", frames_done, 7);
      finish_run();
   end

endmodule